// File: doc/BRIEF.md
# Significand Rounding Unit

This unit finishes a floating-point result. It takes an unrounded significand field, the sign of the value, and two low-order bits kept beyond the field: a guard bit and a sticky bit. It returns the field rounded under one of four selectable modes. Two of the modes use the sign, because they round toward a fixed direction on the number line and not toward a fixed direction in magnitude.

Rounding up can push an all-ones field past its width. When that happens the unit raises a carry-out, and the caller must renormalize and adjust the exponent. The unit also raises an inexact flag whenever precision was dropped. By default the result passes through one output register, so it appears one clock after the inputs. A parameter removes the register and leaves a purely combinational path.

Top module: `sig_round`

## Requirements
- R1: While reset is asserted, `sig_o`, `carry_o` and `inexact_o` are all zero.
- R2: With the output register present, the outputs change only at a rising clock edge and reflect the inputs sampled at that edge, so the latency is one cycle.
- R3: `inexact_o` is 1 exactly when the extra bits `ext_i` (bit 1 is the guard bit, bit 0 is the sticky bit) are not both zero.
- R4: Mode 2'b00 (nearest, ties to even) increments the field when `ext_i` is 2'b11, keeps it when `ext_i` is 2'b01, and for the tie 2'b10 increments only if the field's bit 0 is 1.
- R5: Mode 2'b01 (toward zero) returns `sig_i` unchanged with `carry_o` low, whatever the extra bits are.
- R6: Mode 2'b10 (toward plus infinity) increments the field only when `ext_i` is nonzero and `sign_i` is 0 (positive).
- R7: Mode 2'b11 (toward minus infinity) increments the field only when `ext_i` is nonzero and `sign_i` is 1 (negative).
- R8: When an all-ones field is incremented, `sig_o` becomes zero and `carry_o` is 1. In every other case `carry_o` is 0.
- R9: When `ext_i` is zero, the result equals `sig_i` in every mode and `carry_o` is 0.
- R10: In modes 2'b00 and 2'b01, `sign_i` has no effect on `sig_o` or `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Rounding mode select |
| sign_i | input | 1 | Sign of the value, 1 for negative |
| sig_i | input | SIG_W | Unrounded significand field |
| ext_i | input | 2 | Guard bit (bit 1) and sticky bit (bit 0) |
| sig_o | output | SIG_W | Rounded significand field |
| carry_o | output | 1 | Rounding overflowed the field |
| inexact_o | output | 1 | Precision was discarded |

## Verification
The unit holds no state except its output register, so any error in the increment decision or in the adder shows up at the ports on the very next cycle. A decision error shows as a field that is off by one. An error in carry propagation shows as a wrong `carry_o`, or as a nonzero field after an all-ones increment. The bench therefore sweeps every combination of mode, sign, field and extra bits at a small width, compares each result one cycle later, and also checks the register timing and the reset values.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'b00,
      RND_ZERO      = 2'b01,
      RND_UP        = 2'b10,
      RND_DOWN      = 2'b11
   } rnd_mode_e;

   localparam int EXT_W = 2;
endpackage

// File: rtl/rnd_decide.sv
// Decides whether the magnitude must grow by one unit in the last place.
module rnd_decide
   import rnd_pkg::*;
(
   input  logic [1:0]       mode,
   input  logic             sign,
   input  logic             lsb,
   input  logic [EXT_W-1:0] ext,
   output logic             bump,
   output logic             lost
);
   logic guard_b;
   logic sticky_b;
   rnd_mode_e m;

   always_comb begin
      guard_b  = ext[EXT_W-1];
      sticky_b = ext[0];
      lost     = guard_b | sticky_b;
      m        = rnd_mode_e'(mode);
      unique case (m)
         RND_NEAR_EVEN: bump = guard_b & (sticky_b | lsb);
         RND_ZERO:      bump = 1'b0;
         RND_UP:        bump = lost & ~sign;
         RND_DOWN:      bump = lost & sign;
         default:       bump = 1'b0;
      endcase
   end
endmodule

// File: rtl/rnd_incr.sv
// Adds a one-bit increment to a W-bit field, choosing an explicit ripple chain
// or an inferred adder.
module rnd_incr #(
   parameter int W      = 23,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   if (W < 1) begin : g_bad_w
      $error("rnd_incr: W must be positive");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = cin;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum[i]  = a[i] ^ c[i];
         assign c[i+1]  = a[i] & c[i];
      end
      assign cout = c[W];
   end else begin : g_infer
      logic [W:0] wide;
      assign wide = {1'b0, a} + {{W{1'b0}}, cin};
      assign sum  = wide[W-1:0];
      assign cout = wide[W];
   end
endmodule

// File: rtl/sig_round.sv
module sig_round
   import rnd_pkg::*;
#(
   parameter int SIG_W   = 23,
   parameter bit REG_OUT = 1'b1,
   parameter bit RIPPLE  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             sign_i,
   input  logic [SIG_W-1:0] sig_i,
   input  logic [1:0]       ext_i,
   output logic [SIG_W-1:0] sig_o,
   output logic             carry_o,
   output logic             inexact_o
);
   if (SIG_W < 2) begin : g_bad_sig
      $error("sig_round: SIG_W must be at least 2");
   end

   logic             bump;
   logic             lost;
   logic [SIG_W-1:0] sig_n;
   logic             carry_n;

   rnd_decide u_dec (
      .mode (mode_i),
      .sign (sign_i),
      .lsb  (sig_i[0]),
      .ext  (ext_i),
      .bump (bump),
      .lost (lost)
   );

   rnd_incr #(.W(SIG_W), .RIPPLE(RIPPLE)) u_inc (
      .a    (sig_i),
      .cin  (bump),
      .sum  (sig_n),
      .cout (carry_n)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sig_o     <= '0;
            carry_o   <= 1'b0;
            inexact_o <= 1'b0;
         end else begin
            sig_o     <= sig_n;
            carry_o   <= carry_n;
            inexact_o <= lost;
         end
      end
   end else begin : g_comb
      assign sig_o     = rst_n ? sig_n   : '0;
      assign carry_o   = rst_n & carry_n;
      assign inexact_o = rst_n & lost;
   end
endmodule

// File: rtl/sig_round_chk.sv
module sig_round_chk #(
   parameter int SIG_W   = 23,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             sign_i,
   input logic [SIG_W-1:0] sig_i,
   input logic [1:0]       ext_i,
   input logic [SIG_W-1:0] sig_o,
   input logic             carry_o,
   input logic             inexact_o
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R8
   carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |-> (sig_o == '0));

   if (REG_OUT) begin : g_seq
      // R3
      inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (inexact_o == ($past(ext_i) != 2'b00)));
      // R5
      trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $past(mode_i) == 2'b01) |-> (sig_o == $past(sig_i) && !carry_o));
      // R9
      exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && $past(ext_i) == 2'b00) |-> (sig_o == $past(sig_i) && !carry_o));
      // R8
      carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && carry_o) |-> ($past(sig_i) == {SIG_W{1'b1}}));
   end else begin : g_comb
      // R3
      inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         inexact_o == (ext_i != 2'b00));
      // R5
      trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == 2'b01) |-> (sig_o == sig_i && !carry_o));
      // R9
      exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ext_i == 2'b00) |-> (sig_o == sig_i && !carry_o));
      // R8
      carry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         carry_o |-> (sig_i == {SIG_W{1'b1}}));
   end
endmodule

bind sig_round sig_round_chk #(.SIG_W(SIG_W), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .sign_i    (sign_i),
   .sig_i     (sig_i),
   .ext_i     (ext_i),
   .sig_o     (sig_o),
   .carry_o   (carry_o),
   .inexact_o (inexact_o)
);

// File: tb/sim_sig_round.sv
`timescale 1ns/1ps
module sim_sig_round;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_i = 2'b00;
   logic         sign_i = 1'b0;
   logic [W-1:0] sig_i = '0;
   logic [1:0]   ext_i = 2'b00;
   logic [W-1:0] sig_o;
   logic         carry_o;
   logic         inexact_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sig_round #(.SIG_W(W), .REG_OUT(1'b1), .RIPPLE(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sign_i(sign_i),
      .sig_i(sig_i), .ext_i(ext_i), .sig_o(sig_o), .carry_o(carry_o),
      .inexact_o(inexact_o)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (mode=%0d sign=%0d sig=%0d ext=%0d)",
                  req, actual, expected, mode_i, sign_i, sig_i, ext_i);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset values with busy inputs
      mode_i = 2'b10; sig_i = '1; ext_i = 2'b11;
      repeat (3) @(negedge clk);
      check("R1 sig", int'(sig_o), 0);
      check("R1 carry", int'(carry_o), 0);
      check("R1 inexact", int'(inexact_o), 0);
      rst_n = 1'b1;

      // R2: an input change between edges does not reach the outputs early
      mode_i = 2'b01; sig_i = 4'd5; ext_i = 2'b00;
      @(posedge clk); @(negedge clk);
      check("R2 before", int'(sig_o), 5);
      sig_i = 4'd9;
      #1;
      check("R2 hold", int'(sig_o), 5);
      @(posedge clk); @(negedge clk);
      check("R2 after", int'(sig_o), 9);

      // Exhaustive sweep: value in quarter units is sig*4 + ext
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 16; v++) begin
               for (int e = 0; e < 4; e++) begin
                  int up;
                  int res;
                  string req;
                  mode_i = 2'(m); sign_i = 1'(s); sig_i = 4'(v); ext_i = 2'(e);
                  case (m)
                     0: begin
                        up = (e > 2 || (e == 2 && (v % 2) == 1)) ? 1 : 0;
                        req = "R4 R10";
                     end
                     1: begin up = 0; req = "R5 R10"; end
                     2: begin up = (e != 0 && s == 0) ? 1 : 0; req = "R6"; end
                     default: begin up = (e != 0 && s == 1) ? 1 : 0; req = "R7"; end
                  endcase
                  if (e == 0) req = {req, " R9"};
                  res = v + up;
                  @(posedge clk); @(negedge clk);
                  check(req, int'(sig_o), res % 16);
                  check("R8 carry", int'(carry_o), (res >= 16) ? 1 : 0);
                  check("R3 inexact", int'(inexact_o), (e != 0) ? 1 : 0);
               end
            end
         end
      end

      // R1: reset again in the middle of a run
      mode_i = 2'b00; sig_i = 4'd7; ext_i = 2'b11;
      @(posedge clk); @(negedge clk);
      check("R8 setup", int'(sig_o), 8);
      rst_n = 1'b0;
      #1;
      check("R1 midrun sig", int'(sig_o), 0);
      check("R1 midrun inexact", int'(inexact_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule